// File: doc/BRIEF.md
# Half-Bridge PWM Dead-Time Generator

This block turns one single-ended PWM input into two gate commands for a half-bridge: a high-side command and a low-side command. The low-side command is the complement of the PWM, but it is held off for a programmable number of clock cycles around every high-side pulse. This keeps the two switches from conducting at the same time. The high-side command is the qualified PWM delayed by a fixed amount. Both of its edges therefore move together, and the dead-time settings never change its pulse width. Each gate leaves the block as a pair of drive enables, one for the pull-up and one for the pull-down. The block also gives an early copy of the low-side command for logic that needs to look ahead.

The input passes first through a pulse qualifier. This state machine has the states `QS_OFF`, `QS_LOW`, `QS_RISE`, `QS_HIGH` and `QS_FALL`. It leaves `QS_OFF` for `QS_LOW` once the block is enabled. From a settled state it moves to the qualifying state (`QS_LOW`->`QS_RISE`, `QS_HIGH`->`QS_FALL`) when the input differs. It commits (`QS_RISE`->`QS_HIGH`, `QS_FALL`->`QS_LOW`) after `MIN_PW` consecutive samples at the new level. It falls back to the previous settled state (`QS_RISE`->`QS_LOW`, `QS_FALL`->`QS_HIGH`) if the input returns before then. Losing the enable sends any state to `QS_OFF`.

The qualified level then runs down a delay line that carries a valid bit beside each sample. The low-side command is true only when every sample inside a window around the high-side tap is valid and low. The window reaches `dt_lh` samples ahead of the tap and `dt_hl` samples behind it. All outputs are released only while the supply-good flag is high and the active-low enable is low. Both conditions are registered once.

Top module: `hb_deadtime_gen`

## Requirements
- R1: The high-side command is high for exactly as many cycles as the qualified input was high. The dead-time settings do not change this width, and each qualified input pulse gives exactly one high-side pulse.
- R2: A high-side edge appears `MIN_PW + 2**DT_W - 1 + LEAD` cycles after the clock edge that first samples the matching input edge. With the default parameters this is 20 cycles.
- R3: The low-side command rises exactly `dt_hl` cycles after the high-side command falls. A value of 0 means it rises in the same cycle.
- R4: The low-side command falls exactly `dt_lh` cycles before the high-side command rises. A value of 0 means it falls in the same cycle.
- R5: Each `*_pu_on` output at 1 means the pull-up drives high, and at 0 it means high impedance. Each `*_pd_on` output at 1 means the pull-down drives low. The two outputs of a pair are never 1 together, and while the block is active exactly one of each pair is 1.
- R6: While the block is active and the input is steadily high, `hs_pu_on`=1 and `ls_pd_on`=1, and the other two are 0. While the input is steadily low, `hs_pd_on`=1 and `ls_pu_on`=1, and the other two are 0.
- R7: When `en_n`=1 or `supply_ok`=0 is sampled, all four pad enables and `ls_early` are 0 from the next cycle on. Outputs are active only while both conditions hold.
- R8: `ls_early` carries the low-side command `LEAD` cycles ahead. Its rising and falling edges come `LEAD` cycles before those of `ls_pu_on`.
- R9: An input level held for fewer than `MIN_PW` samples is dropped and produces no gate edge. A level held for exactly `MIN_PW` samples passes with its full width.
- R10: `hs_pu_on` and `ls_pu_on` are never 1 in the same cycle, for any dead-time setting including zero.
- R11: If the input toggles back before a pending low-side turn-on has finished counting, that turn-on is cancelled and the low-side command stays off.
- R12: In the first active cycle after the enable returns, both gates are off (`hs_pd_on`=1, `ls_pd_on`=1). The low side turns on only after the delay line has refilled, and the high side only after a newly qualified high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Single-ended PWM command |
| en_n | input | 1 | Active-low enable |
| supply_ok | input | 1 | Digitised supply-good flag |
| dt_hl | input | DT_W | Cycles from high-side falling to low-side rising |
| dt_lh | input | DT_W | Cycles from low-side falling to high-side rising |
| hs_pu_on | output | 1 | High-side pull-up drives high (0 = high impedance) |
| hs_pd_on | output | 1 | High-side pull-down drives low (0 = high impedance) |
| ls_pu_on | output | 1 | Low-side pull-up drives high (0 = high impedance) |
| ls_pd_on | output | 1 | Low-side pull-down drives low (0 = high impedance) |
| ls_early | output | 1 | Low-side command, LEAD cycles ahead |

## Verification
The hardest situation to reach is a low-side turn-on that is still counting down its dead time when the input comes back high. The PWM has to bounce in less than `dt_hl + dt_lh + 1` qualified cycles, yet each level must still last `MIN_PW` samples so that the qualifier does not simply drop it. The stimulus sets a long `dt_hl` and drives high 6, low 4, high 6 cycles. It then checks that the low side falls once and rises once. A second hard case is losing the enable in the middle of a high-side pulse. The stimulus releases the enable while the high side is on, then re-enables with the input low and checks the both-off restart cycle before the low side comes back.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;
    typedef enum logic [2:0] {
        QS_OFF  = 3'd0,
        QS_LOW  = 3'd1,
        QS_RISE = 3'd2,
        QS_HIGH = 3'd3,
        QS_FALL = 3'd4
    } qual_state_e;
endpackage

// File: rtl/hb_pulse_qual.sv
// Minimum pulse-width qualifier: a new level is committed only after
// MIN_PW consecutive samples; both edges are delayed alike.
module hb_pulse_qual
    import hb_dt_pkg::*;
#(
    parameter int unsigned MIN_PW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pwm_raw,
    output logic level,
    output logic live
);
    localparam int unsigned CW = $clog2(MIN_PW + 1);

    qual_state_e    st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= QS_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!run) begin
            st_d  = QS_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                QS_OFF:  st_d = QS_LOW;
                QS_LOW:  if (pwm_raw) begin
                             st_d  = QS_RISE;
                             cnt_d = CW'(1);
                         end
                QS_RISE: if (!pwm_raw)                   st_d = QS_LOW;
                         else if (cnt_q == CW'(MIN_PW - 1)) st_d = QS_HIGH;
                         else                            cnt_d = cnt_q + 1'b1;
                QS_HIGH: if (!pwm_raw) begin
                             st_d  = QS_FALL;
                             cnt_d = CW'(1);
                         end
                QS_FALL: if (pwm_raw)                    st_d = QS_HIGH;
                         else if (cnt_q == CW'(MIN_PW - 1)) st_d = QS_LOW;
                         else                            cnt_d = cnt_q + 1'b1;
                default: st_d = QS_OFF;
            endcase
        end
    end

    always_comb begin
        level = (st_q == QS_HIGH) || (st_q == QS_FALL);
        live  = (st_q != QS_OFF);
    end
endmodule

// File: rtl/hb_delay_line.sv
// Shift register of qualified samples with a valid bit per stage.
module hb_delay_line #(
    parameter int unsigned DEPTH = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             live,
    input  logic             level,
    output logic [DEPTH-1:0] lvl_q,
    output logic [DEPTH-1:0] vld_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            vld_q <= '0;
        end else begin
            lvl_q <= {lvl_q[DEPTH-2:0], level};
            if (!run) vld_q <= '0;
            else      vld_q <= {vld_q[DEPTH-2:0], live};
        end
    end
endmodule

// File: rtl/hb_window.sv
// Low-side permission: every sample from BASE-dt_lh to BASE+dt_hl
// must be valid and low.
module hb_window #(
    parameter int unsigned DEPTH = 33,
    parameter int unsigned DT_W  = 4,
    parameter int unsigned BASE  = 17
) (
    input  logic [DEPTH-1:0] lvl,
    input  logic [DEPTH-1:0] vld,
    input  logic [DT_W-1:0]  dt_hl,
    input  logic [DT_W-1:0]  dt_lh,
    output logic             gate_on
);
    always_comb begin
        int   lo;
        int   hi;
        logic any_hi;
        logic all_v;
        lo     = int'(BASE) - int'(dt_lh);
        hi     = int'(BASE) + int'(dt_hl);
        any_hi = 1'b0;
        all_v  = 1'b1;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (i >= lo && i <= hi) begin
                any_hi = any_hi | lvl[i];
                all_v  = all_v & vld[i];
            end
        end
        gate_on = all_v & ~any_hi;
    end
endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen #(
    parameter int unsigned DT_W   = 4,
    parameter int unsigned LEAD   = 2,
    parameter int unsigned MIN_PW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic            en_n,
    input  logic            supply_ok,
    input  logic [DT_W-1:0] dt_hl,
    input  logic [DT_W-1:0] dt_lh,
    output logic            hs_pu_on,
    output logic            hs_pd_on,
    output logic            ls_pu_on,
    output logic            ls_pd_on,
    output logic            ls_early
);
    localparam int unsigned MAX_DT = (1 << DT_W) - 1;
    localparam int unsigned HS_TAP = MAX_DT + LEAD;
    localparam int unsigned DEPTH  = HS_TAP + MAX_DT + 1;

    logic             en_now, act_q;
    logic             q_level, q_live;
    logic [DEPTH-1:0] lvl, vld;
    logic [1:0]       ls_win;
    logic             hs_raw, hs_g, ls_g;

    assign en_now = supply_ok & ~en_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= en_now;
    end

    hb_pulse_qual #(.MIN_PW(MIN_PW)) i_qual (
        .clk(clk), .rst_n(rst_n), .run(en_now), .pwm_raw(pwm_in),
        .level(q_level), .live(q_live)
    );

    hb_delay_line #(.DEPTH(DEPTH)) i_line (
        .clk(clk), .rst_n(rst_n), .run(en_now), .live(q_live),
        .level(q_level), .lvl_q(lvl), .vld_q(vld)
    );

    // g=0: low-side command at the gate tap; g=1: LEAD cycles earlier
    for (genvar g = 0; g < 2; g++) begin : g_win
        hb_window #(.DEPTH(DEPTH), .DT_W(DT_W), .BASE(HS_TAP - g * LEAD)) i_win (
            .lvl(lvl), .vld(vld), .dt_hl(dt_hl), .dt_lh(dt_lh),
            .gate_on(ls_win[g])
        );
    end

    always_comb begin
        hs_raw = vld[HS_TAP] & lvl[HS_TAP];
        // same-cycle conflict resolves to both gates low
        hs_g   = hs_raw & ~ls_win[0];
        ls_g   = ls_win[0] & ~hs_raw;
        hs_pu_on = act_q & hs_g;
        hs_pd_on = act_q & ~hs_g;
        ls_pu_on = act_q & ls_g;
        ls_pd_on = act_q & ~ls_g;
        ls_early = act_q & ls_win[1];
    end
endmodule

// File: rtl/hb_dt_checker.sv
module hb_dt_checker (
    input logic clk,
    input logic rst_n,
    input logic en_n,
    input logic supply_ok,
    input logic hs_pu_on,
    input logic hs_pd_on,
    input logic ls_pu_on,
    input logic ls_pd_on,
    input logic ls_early
);
    a_r5_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_pu_on && hs_pd_on) && !(ls_pu_on && ls_pd_on));

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_pu_on && ls_pu_on));

    a_r7_disabled_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok || en_n) |=> !(hs_pu_on || hs_pd_on || ls_pu_on || ls_pd_on || ls_early));

    a_r5_active_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !en_n) |=> (hs_pu_on != hs_pd_on) && (ls_pu_on != ls_pd_on));

    a_r12_restart_off: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !en_n && !$past(supply_ok && !en_n)) |=> (!hs_pu_on && !ls_pu_on));
endmodule

bind hb_deadtime_gen hb_dt_checker i_chk (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .supply_ok(supply_ok),
    .hs_pu_on(hs_pu_on), .hs_pd_on(hs_pd_on), .ls_pu_on(ls_pu_on),
    .ls_pd_on(ls_pd_on), .ls_early(ls_early)
);

// File: tb/test_hb_deadtime_gen.sv
module test_hb_deadtime_gen;
    localparam int DT_W  = 4;
    localparam int LEAD  = 2;
    localparam int MINPW = 3;
    localparam int LAT   = MINPW + (1 << DT_W) - 1 + LEAD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0;
    logic en_n = 1'b1;
    logic supply_ok = 1'b0;
    logic [DT_W-1:0] dt_hl = '0;
    logic [DT_W-1:0] dt_lh = '0;
    logic hs_pu_on, hs_pd_on, ls_pu_on, ls_pd_on, ls_early;

    hb_deadtime_gen #(.DT_W(DT_W), .LEAD(LEAD), .MIN_PW(MINPW)) i_hb_deadtime_gen (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .en_n(en_n),
        .supply_ok(supply_ok), .dt_hl(dt_hl), .dt_lh(dt_lh),
        .hs_pu_on(hs_pu_on), .hs_pd_on(hs_pd_on), .ls_pu_on(ls_pu_on),
        .ls_pd_on(ls_pd_on), .ls_early(ls_early)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // edge monitor, sampled away from the active edge
    int t_hs_r = 0, t_hs_f = 0, t_ls_r = 0, t_ls_f = 0, t_le_r = 0, t_le_f = 0;
    int n_hs_r = 0, n_ls_r = 0, n_ls_f = 0, n_ovl = 0, n_pair = 0;
    bit p_hs = 0, p_ls = 0, p_le = 0;
    always @(negedge clk) begin
        if (hs_pu_on && !p_hs) begin t_hs_r = cyc; n_hs_r++; end
        if (!hs_pu_on && p_hs) t_hs_f = cyc;
        if (ls_pu_on && !p_ls) begin t_ls_r = cyc; n_ls_r++; end
        if (!ls_pu_on && p_ls) begin t_ls_f = cyc; n_ls_f++; end
        if (ls_early && !p_le) t_le_r = cyc;
        if (!ls_early && p_le) t_le_f = cyc;
        if (hs_pu_on && ls_pu_on) n_ovl++;
        if ((hs_pu_on && hs_pd_on) || (ls_pu_on && ls_pd_on)) n_pair++;
        p_hs = hs_pu_on; p_ls = ls_pu_on; p_le = ls_early;
    end

    int n_chk = 0, n_fail = 0;
    bit wd = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pads();
        return {28'd0, hs_pu_on, hs_pd_on, ls_pu_on, ls_pd_on};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; en_n = 1'b1; supply_ok = 1'b0; pwm_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7", "pads after reset while disabled", pads(), 0);
        chk("R7", "early after reset", int'(ls_early), 0);
    endtask

    task automatic t_idle_low();
        dt_hl = 4'd3; dt_lh = 4'd5;
        supply_ok = 1'b1; en_n = 1'b0;
        repeat (60) @(negedge clk);
        chk("R6", "pads steady low {hpu,hpd,lpu,lpd}", pads(), 4'b0110);
        chk("R8", "early steady low", int'(ls_early), 1);
    endtask

    task automatic t_pulse(input int dh, input int dl, input int w);
        int t0;
        dt_hl = DT_W'(dh); dt_lh = DT_W'(dl);
        repeat (40) @(negedge clk);
        pwm_in = 1'b1; t0 = cyc + 1;
        repeat (w) @(negedge clk);
        pwm_in = 1'b0;
        repeat (70) @(negedge clk);
        chk("R2", "hs rise latency", t_hs_r - t0, LAT);
        chk("R1", "hs width", t_hs_f - t_hs_r, w);
        chk("R4", "ls fall lead before hs rise", t_hs_r - t_ls_f, dl);
        chk("R3", "ls rise after hs fall", t_ls_r - t_hs_f, dh);
        chk("R8", "early fall lead", t_ls_f - t_le_f, LEAD);
        chk("R8", "early rise lead", t_ls_r - t_le_r, LEAD);
    endtask

    task automatic t_steady_high();
        dt_hl = 4'd2; dt_lh = 4'd2;
        pwm_in = 1'b1;
        repeat (60) @(negedge clk);
        chk("R6", "pads steady high {hpu,hpd,lpu,lpd}", pads(), 4'b1001);
        pwm_in = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic t_short();
        int h0, l0, t0;
        h0 = n_hs_r; l0 = n_ls_f;
        dt_hl = 4'd1; dt_lh = 4'd1;
        pwm_in = 1'b1;
        repeat (MINPW - 1) @(negedge clk);
        pwm_in = 1'b0;
        repeat (60) @(negedge clk);
        chk("R9", "short pulse hs rises", n_hs_r - h0, 0);
        chk("R9", "short pulse ls falls", n_ls_f - l0, 0);
        pwm_in = 1'b1; t0 = cyc + 1;
        repeat (MINPW) @(negedge clk);
        pwm_in = 1'b0;
        repeat (60) @(negedge clk);
        chk("R9", "min pulse hs rises", n_hs_r - h0, 1);
        chk("R9", "min pulse hs width", t_hs_f - t_hs_r, MINPW);
        chk("R2", "min pulse latency", t_hs_r - t0, LAT);
    endtask

    task automatic t_cancel();
        int h0, lf0, lr0;
        dt_hl = 4'd10; dt_lh = 4'd2;
        repeat (40) @(negedge clk);
        h0 = n_hs_r; lf0 = n_ls_f; lr0 = n_ls_r;
        pwm_in = 1'b1; repeat (6) @(negedge clk);
        pwm_in = 1'b0; repeat (4) @(negedge clk);
        pwm_in = 1'b1; repeat (6) @(negedge clk);
        pwm_in = 1'b0;
        repeat (80) @(negedge clk);
        chk("R1", "bounce hs pulses", n_hs_r - h0, 2);
        chk("R11", "bounce ls falls", n_ls_f - lf0, 1);
        chk("R11", "bounce ls rises", n_ls_r - lr0, 1);
        chk("R3", "bounce ls rise after last hs fall", t_ls_r - t_hs_f, 10);
    endtask

    task automatic t_disable(input bit via_supply);
        dt_hl = 4'd3; dt_lh = 4'd3;
        pwm_in = 1'b1;
        repeat (40) @(negedge clk);
        chk("R6", "hs on before drop", int'(hs_pu_on), 1);
        if (via_supply) supply_ok = 1'b0; else en_n = 1'b1;
        @(negedge clk);
        chk("R7", via_supply ? "pads after supply loss" : "pads after enable release",
            pads(), 0);
        chk("R7", "early after drop", int'(ls_early), 0);
        pwm_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7", "pads stay off", pads(), 0);
        supply_ok = 1'b1; en_n = 1'b0;
        @(negedge clk);
        chk("R12", "restart pads {hpu,hpd,lpu,lpd}", pads(), 4'b0101);
        repeat (50) @(negedge clk);
        chk("R12", "ls back after refill", pads(), 4'b0110);
    endtask

    task automatic run_all();
        t_reset();
        t_idle_low();
        t_pulse(3, 5, 10);
        t_pulse(0, 0, 7);
        t_pulse(15, 15, 8);
        t_pulse(9, 1, 25);
        t_steady_high();
        t_short();
        t_cancel();
        t_disable(1'b0);
        t_disable(1'b1);
        chk("R10", "cycles with both gates on", n_ovl, 0);
        chk("R5", "cycles with a pair both on", n_pair, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule